// File: doc/BRIEF.md
# NAND Read-Retry Table Fetch Sequencer

This block runs, on a single start pulse, the fixed command script that makes a multi-level-cell NAND device expose the hidden one-time-programmable page that holds its read-retry tables. It reads that page and then puts the device back into normal operation. The block drives a simplified raw NAND bus: one-cycle command, address and data strobes, with the byte on a shared output. Page reads are not performed here. They are handed to a downstream page-read engine through a start/done/error handshake that carries a page address and a byte count.

The script runs in order. First the device is reset. Then the block enters parameter mode, writes the selector register with the unlock value and applies it. Three entry commands follow. Next comes a page read at the page address and byte count captured from the requester when the run was started. The restore phase then resets the device, writes zero into the selector register, applies it, and finishes with an empty read of page 0. After each reset command the block holds until the device ready input is high. A read error from the page-read engine ends the run at once.

Top module: `rrtable_fetch`

## Requirements
- R1: While reset is held and after it is released, busy, done, error, all three bus strobes, pgStart, busOut, pgAddr and pgLen are 0.
- R2: A run begins with a command strobe carrying 0xFF (device reset). After each 0xFF command, no further strobe or read request is issued until devReady has been sampled high.
- R3: After the first reset the bus carries, in order: command 0x36, an address strobe with 0x38, a data strobe with 0x52, and command 0x16.
- R4: Next come three back-to-back command strobes carrying 0x17, 0x04 and 0x19, in that order.
- R5: Next, pgStart pulses for one cycle with pgAddr and pgLen equal to the reqPage and reqLen sampled in the cycle start was accepted. Later changes on reqPage and reqLen have no effect on them.
- R6: After pgDone for that read, the restore phase carries, in order: command 0xFF, command 0x36, address 0x38, data 0x00, command 0x16.
- R7: The last step is a read request with pgAddr = 0 and pgLen = 0.
- R8: done is high for exactly one cycle, one cycle after pgDone of the final read is sampled, and busy is low in that cycle. done never rises earlier in the run.
- R9: If pgErr is sampled while a read is pending, error goes high and busy goes low in the next cycle, and no further bus strobe or read request follows. error stays high until the next accepted start, which clears it.
- R10: A start pulse while busy is high is ignored. The running script and its captured page and length are unchanged, and no second run follows.
- R11: At most one of the command, address, data strobes and pgStart is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| reqPage | input | PAGE_W | Page address of the table page |
| reqLen | input | LEN_W | Byte count of the table read |
| devReady | input | 1 | Device ready (high = idle) |
| cmdLatch | output | 1 | Command strobe, one cycle per byte |
| addrLatch | output | 1 | Address strobe, one cycle per byte |
| dataLatch | output | 1 | Write-data strobe, one cycle per byte |
| busOut | output | 8 | Byte carried by the active strobe |
| pgStart | output | 1 | One-cycle page-read request |
| pgAddr | output | PAGE_W | Page address of the request |
| pgLen | output | LEN_W | Byte count of the request |
| pgDone | input | 1 | Page-read engine finished |
| pgErr | input | 1 | Page-read engine failed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last run aborted on a read error |

## Verification
Assertions check several properties on every cycle. No two strobes may be high together. No step may go out while the device is not ready. done must be a lone pulse outside busy. A read error must drop busy and raise error. Only the bench scenarios can show the content of the sequence: the byte order of each phase, the captured page and length on both reads, the wait after each reset measured against the moment ready rises, the timing of done, the silence on the bus after an abort, and that a start during a run is ignored.

// File: rtl/rrtable_fetch_pkg.sv
package rrtable_fetch_pkg;

  localparam int NUM_STEPS = 15;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] FIRST_READ = STEP_W'(8);
  localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(NUM_STEPS - 1);

  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_PARAM   = 8'h36;
  localparam logic [7:0] OP_APPLY   = 8'h16;
  localparam logic [7:0] OP_ENTRY_A = 8'h17;
  localparam logic [7:0] OP_ENTRY_B = 8'h04;
  localparam logic [7:0] OP_ENTRY_C = 8'h19;
  localparam logic [7:0] SEL_REG    = 8'h38;
  localparam logic [7:0] SEL_UNLOCK = 8'h52;
  localparam logic [7:0] SEL_NORMAL = 8'h00;

  typedef enum logic [1:0] {K_CMD, K_ADDR, K_DATA, K_READ} stepKind_t;

  typedef struct packed {
    stepKind_t  kind;
    logic [7:0] val;
  } step_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       cmd;
    logic       addr;
    logic       data;
    logic       rd;
    logic       dummy;
    logic       capture;
    logic [7:0] val;
  } strobe_t;

  function automatic step_t stepAt(input logic [STEP_W-1:0] idx);
    step_t s;
    case (idx)
      4'd0:    s = '{kind: K_CMD,  val: OP_RESET};
      4'd1:    s = '{kind: K_CMD,  val: OP_PARAM};
      4'd2:    s = '{kind: K_ADDR, val: SEL_REG};
      4'd3:    s = '{kind: K_DATA, val: SEL_UNLOCK};
      4'd4:    s = '{kind: K_CMD,  val: OP_APPLY};
      4'd5:    s = '{kind: K_CMD,  val: OP_ENTRY_A};
      4'd6:    s = '{kind: K_CMD,  val: OP_ENTRY_B};
      4'd7:    s = '{kind: K_CMD,  val: OP_ENTRY_C};
      4'd8:    s = '{kind: K_READ, val: 8'h00};
      4'd9:    s = '{kind: K_CMD,  val: OP_RESET};
      4'd10:   s = '{kind: K_CMD,  val: OP_PARAM};
      4'd11:   s = '{kind: K_ADDR, val: SEL_REG};
      4'd12:   s = '{kind: K_DATA, val: SEL_NORMAL};
      4'd13:   s = '{kind: K_CMD,  val: OP_APPLY};
      default: s = '{kind: K_READ, val: 8'h00};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rrtable_fetch_ctrl.sv
module rrtable_fetch_ctrl
  import rrtable_fetch_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    devReady,
  input  logic    pgDone,
  input  logic    pgErr,
  output strobe_t strobe,
  output logic    busy,
  output logic    done,
  output logic    error
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT_RDY, S_WAIT_PG} state_t;

  state_t            state;
  logic [STEP_W-1:0] stepIdx;
  step_t             cur;

  assign cur  = stepAt(stepIdx);
  assign busy = (state != S_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.capture = (state == S_IDLE) && start;
    if (state == S_ISSUE) begin
      strobe.cmd   = (cur.kind == K_CMD);
      strobe.addr  = (cur.kind == K_ADDR);
      strobe.data  = (cur.kind == K_DATA);
      strobe.rd    = (cur.kind == K_READ);
      strobe.dummy = (stepIdx == LAST_STEP);
      strobe.val   = cur.val;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_ISSUE;
          stepIdx <= '0;
          error   <= 1'b0;
        end
        S_ISSUE: begin
          if (cur.kind == K_READ)
            state <= S_WAIT_PG;
          else if (cur.kind == K_CMD && cur.val == OP_RESET)
            state <= S_WAIT_RDY;
          else
            stepIdx <= stepIdx + 1'b1;
        end
        S_WAIT_RDY: if (devReady) begin
          state   <= S_ISSUE;
          stepIdx <= stepIdx + 1'b1;
        end
        S_WAIT_PG: begin
          if (pgErr) begin
            error <= 1'b1;
            state <= S_IDLE;
          end else if (pgDone) begin
            if (stepIdx == LAST_STEP) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              stepIdx <= stepIdx + 1'b1;
              state   <= S_ISSUE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ready_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_RDY && !devReady) |=> !(strobe.cmd || strobe.addr || strobe.data || strobe.rd));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_PG && pgErr) |=> (error && !busy));

endmodule

// File: rtl/rrtable_fetch_datapath.sv
module rrtable_fetch_datapath
  import rrtable_fetch_pkg::*;
#(
  parameter int PAGE_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              cmdLatch,
  output logic              addrLatch,
  output logic              dataLatch,
  output logic [7:0]        busOut,
  output logic              pgStart,
  output logic [PAGE_W-1:0] pgAddr,
  output logic [LEN_W-1:0]  pgLen
);

  logic [PAGE_W-1:0] pageHold;
  logic [LEN_W-1:0]  lenHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageHold <= '0;
      lenHold  <= '0;
    end else if (strobe.capture) begin
      pageHold <= reqPage;
      lenHold  <= reqLen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdLatch  <= 1'b0;
      addrLatch <= 1'b0;
      dataLatch <= 1'b0;
      busOut    <= '0;
      pgStart   <= 1'b0;
      pgAddr    <= '0;
      pgLen     <= '0;
    end else begin
      cmdLatch  <= strobe.cmd;
      addrLatch <= strobe.addr;
      dataLatch <= strobe.data;
      busOut    <= (strobe.cmd || strobe.addr || strobe.data) ? strobe.val : 8'h00;
      pgStart   <= strobe.rd;
      if (strobe.rd) begin
        pgAddr <= strobe.dummy ? '0 : pageHold;
        pgLen  <= strobe.dummy ? '0 : lenHold;
      end
    end
  end

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdLatch, addrLatch, dataLatch, pgStart}));

  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    pgStart |=> !pgStart);

endmodule

// File: rtl/rrtable_fetch.sv
module rrtable_fetch
  import rrtable_fetch_pkg::*;
#(
  parameter int PAGE_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              devReady,
  output logic              cmdLatch,
  output logic              addrLatch,
  output logic              dataLatch,
  output logic [7:0]        busOut,
  output logic              pgStart,
  output logic [PAGE_W-1:0] pgAddr,
  output logic [LEN_W-1:0]  pgLen,
  input  logic              pgDone,
  input  logic              pgErr,
  output logic              busy,
  output logic              done,
  output logic              error
);

  strobe_t strobe;

  rrtable_fetch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .devReady (devReady),
    .pgDone   (pgDone),
    .pgErr    (pgErr),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  rrtable_fetch_datapath #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqPage   (reqPage),
    .reqLen    (reqLen),
    .cmdLatch  (cmdLatch),
    .addrLatch (addrLatch),
    .dataLatch (dataLatch),
    .busOut    (busOut),
    .pgStart   (pgStart),
    .pgAddr    (pgAddr),
    .pgLen     (pgLen)
  );

endmodule

// File: tb/rrtable_fetch_test.sv
`timescale 1ns/1ps
module rrtable_fetch_test;

  localparam int PW = 24;
  localparam int LW = 16;
  localparam int RDY_LAT = 5;
  localparam int ENG_LAT = 4;

  // kind in [9:8]: 0 command, 1 address, 2 data, 3 read request
  localparam logic [9:0] EXP [15] = '{
    10'h0FF, 10'h036, 10'h138, 10'h252, 10'h016, 10'h017, 10'h004, 10'h019,
    10'h300, 10'h0FF, 10'h036, 10'h138, 10'h200, 10'h016, 10'h300};

  logic clk = 0, rstN = 0, start = 0, devReady = 1, pgDone = 0, pgErr = 0;
  logic [PW-1:0] reqPage = '0;
  logic [LW-1:0] reqLen = '0;
  logic cmdLatch, addrLatch, dataLatch, pgStart, busy, done, error;
  logic [7:0] busOut;
  logic [PW-1:0] pgAddr;
  logic [LW-1:0] pgLen;

  rrtable_fetch #(.PAGE_W(PW), .LEN_W(LW)) uut (.*);

  always #4 clk = ~clk;

  int cyc = 0, total = 0, failed = 0;
  logic [9:0] evLog [32];
  int evCyc [32];
  int evCount = 0;
  logic [PW-1:0] rdPage [4];
  logic [LW-1:0] rdLen [4];
  int readsSeen = 0, resetsSeen = 0, riseCyc [4], resetIdx [4];
  int doneCount = 0, doneCyc = 0, lastPgDoneCyc = 0;
  int readyCnt = 0, engCnt = 0;
  bit engFail = 0, failFirstRead = 0;

  initial forever @(posedge clk) cyc++;

  // Monitor plus device and page-engine models
  initial forever begin
    @(negedge clk);
    pgDone = 0; pgErr = 0;
    if (done) begin doneCount++; doneCyc = cyc; end
    if ((cmdLatch || addrLatch || dataLatch || pgStart) && evCount < 32) begin
      evLog[evCount] = {pgStart ? 2'd3 : dataLatch ? 2'd2 : addrLatch ? 2'd1 : 2'd0, busOut};
      evCyc[evCount] = cyc;
      evCount++;
    end
    if (cmdLatch && busOut == 8'hFF) begin
      devReady = 0; readyCnt = RDY_LAT;
      if (resetsSeen < 4) resetIdx[resetsSeen] = evCount - 1;
    end else if (readyCnt > 0) begin
      readyCnt--;
      if (readyCnt == 0) begin
        devReady = 1;
        if (resetsSeen < 4) riseCyc[resetsSeen] = cyc;
        resetsSeen++;
      end
    end
    if (pgStart) begin
      if (readsSeen < 4) begin rdPage[readsSeen] = pgAddr; rdLen[readsSeen] = pgLen; end
      engFail = failFirstRead && readsSeen == 0;
      readsSeen++;
      engCnt = ENG_LAT;
    end else if (engCnt > 0) begin
      engCnt--;
      if (engCnt == 0) begin
        if (engFail) pgErr = 1;
        else begin pgDone = 1; lastPgDoneCyc = cyc; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input int i);
    if (i == 0) return "R2";
    if (i <= 4) return "R3";
    if (i <= 7) return "R4";
    if (i == 8) return "R5";
    if (i <= 13) return "R6";
    return "R7";
  endfunction

  task automatic runSeq(input logic [PW-1:0] pg, input logic [LW-1:0] ln,
                        input bit failFirst, input bit poke);
    evCount = 0; readsSeen = 0; resetsSeen = 0; doneCount = 0;
    failFirstRead = failFirst;
    @(negedge clk); reqPage = pg; reqLen = ln; start = 1;
    @(negedge clk); start = 0; reqPage = ~pg; reqLen = ~ln;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      start = (poke && k == 12);
      if (!busy) break;
    end
    start = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic checkFull(input logic [PW-1:0] pg, input logic [LW-1:0] ln);
    check(evCount == 15, "R10", "event count", evCount, 15);
    for (int i = 0; i < 15; i++)
      check(evLog[i] == EXP[i], reqOf(i), $sformatf("step %0d", i), evLog[i], EXP[i]);
    check(rdPage[0] == pg && rdLen[0] == ln, "R5", "captured page/len",
          {rdPage[0][15:0], rdLen[0]}, {pg[15:0], ln});
    check(rdPage[1] == 0 && rdLen[1] == 0, "R7", "dummy page/len",
          {rdPage[1][15:0], rdLen[1]}, 0);
    for (int r = 0; r < 2; r++)
      check(evCyc[resetIdx[r] + 1] > riseCyc[r], "R2", "step after ready rise",
            evCyc[resetIdx[r] + 1], riseCyc[r] + 1);
    check(doneCount == 1, "R8", "done pulse count", doneCount, 1);
    check(doneCyc == lastPgDoneCyc + 1, "R8", "done timing", doneCyc, lastPgDoneCyc + 1);
    check(error == 0, "R9", "error after good run", error, 0);
  endtask

  initial begin
    #(8 * 150000);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, done, error, cmdLatch, addrLatch, dataLatch, pgStart} == 0 && busOut == 0,
          "R1", "outputs in reset", {busy, done, error, cmdLatch, addrLatch, dataLatch, pgStart}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(busy == 0 && pgAddr == 0 && pgLen == 0 && !pgStart, "R1", "idle after reset",
          {busy, pgAddr[15:0]}, 0);

    // Main table-driven runs
    runSeq(24'h012345, 16'd2048, 0, 0);
    checkFull(24'h012345, 16'd2048);
    runSeq(24'hFFFFFF, 16'd1, 0, 0);
    checkFull(24'hFFFFFF, 16'd1);

    // R10: start while busy is ignored
    runSeq(24'h000200, 16'd512, 0, 1);
    checkFull(24'h000200, 16'd512);

    // R9: read error aborts the run
    runSeq(24'h00ABCD, 16'd64, 1, 0);
    check(evCount == 9, "R9", "no activity after abort", evCount, 9);
    check(error == 1 && busy == 0, "R9", "error and idle", {error, busy}, 2'b10);
    check(doneCount == 0, "R8", "no done on abort", doneCount, 0);
    repeat (5) @(negedge clk);
    check(error == 1, "R9", "error held", error, 1);

    // R9: next start clears error
    @(negedge clk); reqPage = 24'h000777; reqLen = 16'd32; start = 1;
    @(negedge clk); start = 0;
    check(error == 0 && busy == 1, "R9", "error cleared on start", {error, busy}, 2'b01);
    while (busy) @(negedge clk);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule